// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmit/Receive Unit

This block is a master-side synchronous serial port that moves 8-bit words. Software places a byte in a transmit holding buffer through a small register interface. The unit then copies the byte into a separate shift register and drives it out on a data pin. On the opposite edge of the transfer clock it captures a byte from the data input. The transfer clock comes from a baud divider. The divider counts ticks from a prescaler set to full rate, one eighth or one thirty-second of the system clock.

The holding buffer and the shift register are separate, so software can queue the next byte while the current one is still shifting. That byte then follows with no idle gap. Run-time options are set in a control register: clock polarity, bit order, data inversion, gating of frame starts by an active-low clear-to-send input, and the event that raises the transmit interrupt. The register interface is synchronous. Writes take effect on the clock edge. Reads are combinational from the address.

Register map (byte wide, `reg_addr`): 0 = control, 1 = divider N, 2 = transmit buffer (a write queues a byte, a read returns the last written byte), 3 = receive buffer (a read strobe clears the receive flag), 4 = status. Control bits: [1:0] count source, [2] clock polarity, [3] MSB first, [4] invert data, [5] clear-to-send gating, [6] interrupt on completion. Status bits: [0] transmit buffer empty, [1] shift register empty, [2] receive byte ready.

Top module: `ssp_sync_serial`

## Requirements
- R1: After reset, status reads 0x03, `sclk_out` is 1, `sdo` is 1 and `irq_tx` is 0.
- R2: Control bits [1:0] pick the count source: 00 gives a tick on every clock, 01 a tick every 8 clocks, 10 a tick every 32 clocks. 11 gives no ticks, and a queued byte stays in the buffer (status 0x02) until a valid source is picked.
- R3: Each half period of `sclk_out` lasts N+1 source ticks, where N is the divider register. Between frames `sclk_out` rests at 1 when control bit 2 is 0 and at 0 when it is 1.
- R4: `sdo` shows the first bit from the first cycle of a frame. Later bits change only on the clock edge leaving the rest level. `sdi` is captured on the edge returning to the rest level. `sdo` is 1 between frames.
- R5: With control bit 3 at 0 the byte goes out bit 0 first; at 1 it goes out bit 7 first. Received bits are placed in the same order.
- R6: With control bit 4 at 1, both the transmitted and the received bits are inverted. At 0 they pass unchanged.
- R7: A write to address 2 while the shift register is idle loads the shifter on the following clock edge. Status then reads 0x01.
- R8: A byte written while a frame is in progress is loaded as the last bit of that frame is captured. Two queued bytes keep status bit 1 at 0 for 32 consecutive cycles when the source is 00 and N=0.
- R9: After the eighth capture edge, the received byte appears at address 3 and status bit 2 is set. A read strobe at address 3 clears status bit 2.
- R10: With control bit 5 at 1, a frame starts only while `cts_n` is 0. A queued byte waits while `cts_n` is 1.
- R11: `irq_tx` is a one-cycle pulse. With control bit 6 at 0 it fires on each buffer-to-shifter transfer. With bit 6 at 1 it fires only when a frame ends with no byte waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cts_n | input | 1 | Active-low clear-to-send |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Transfer clock out |
| irq_tx | output | 1 | Transmit interrupt pulse |

## Verification
The hardest case to reach is the frame boundary where a queued byte is loaded in the same cycle as the last capture edge. On that cycle the receive latch, the shifter reload and the interrupt choice all happen together. The stimulus reaches it by writing a second byte right after the first one loads, with the fastest clock setting. It then repeats this with the interrupt on completion, so that the back-to-back path and the finish path each meet that edge. A cycle-accurate reference model follows every output. Leading-edge captures of `sdo` check bit order and inversion independently of the model.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef struct packed {
    logic       irq_on_done;
    logic       cts_en;
    logic       invert;
    logic       msb_first;
    logic       clk_pol;
    logic [1:0] src_sel;
  } ctrl_t;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_DIV    = 3'd1;
  localparam logic [2:0] A_TXBUF  = 3'd2;
  localparam logic [2:0] A_RXBUF  = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;

  localparam logic [1:0] SRC_OFF = 2'b11;

  // bit presented on the data line for a given shifter content
  function automatic logic head_bit(input logic [7:0] sh, input logic msb);
    return msb ? sh[7] : sh[0];
  endfunction

  // advance the transmit shifter by one position
  function automatic logic [7:0] tx_advance(input logic [7:0] sh, input logic msb);
    return msb ? {sh[6:0], 1'b0} : {1'b0, sh[7:1]};
  endfunction

  // insert one captured bit into the receive shifter
  function automatic logic [7:0] rx_insert(input logic [7:0] sh, input logic b, input logic msb);
    return msb ? {sh[6:0], b} : {b, sh[7:1]};
  endfunction

endpackage

// File: rtl/ssp_prescale.sv
module ssp_prescale #(
  parameter int MID_DIV  = 8,
  parameter int SLOW_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  output logic       src_tick
);
  localparam int PW = $clog2(SLOW_DIV);
  localparam logic [PW-1:0] MID_MASK  = PW'(MID_DIV - 1);
  localparam logic [PW-1:0] SLOW_MASK = PW'(SLOW_DIV - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_comb begin
    case (src_sel)
      2'b00:   src_tick = 1'b1;
      2'b01:   src_tick = ((cnt & MID_MASK) == MID_MASK);
      2'b10:   src_tick = (cnt == SLOW_MASK);
      default: src_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             tick,
  input  logic [DIV_W-1:0] n,
  output logic             stb
);
  logic [DIV_W-1:0] cnt;

  assign stb = run && tick && (cnt == n);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (run && tick)  cnt <= stb ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              wr_buf,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_clr,
  input  logic              cts_n,
  input  logic              sdi,
  input  logic              stb,
  output logic              busy,
  output logic              lvl,
  output logic              load_evt,
  output logic              frame_end,
  output logic              done_evt,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_q,
  output logic [DATA_W-1:0] rx_q,
  output logic              rx_full,
  output logic              sdo,
  output logic              irq_tx
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
  logic [CW-1:0]     bit_cnt;
  logic              cts_ok, src_ok, can_start;

  assign cts_ok    = !ctrl.cts_en || !cts_n;
  assign src_ok    = (ctrl.src_sel != SRC_OFF);
  assign can_start = buf_full && cts_ok && src_ok;
  assign frame_end = busy && stb && !lvl && (bit_cnt == LAST_BIT);
  assign load_evt  = can_start && (!busy || frame_end);
  assign done_evt  = frame_end && !can_start;
  assign rx_next   = rx_insert(rx_sh, sdi ^ ctrl.invert, ctrl.msb_first);
  assign sdo       = busy ? (head_bit(tx_sh, ctrl.msb_first) ^ ctrl.invert) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lvl     <= 1'b1;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
      irq_tx  <= 1'b0;
    end else begin
      irq_tx <= ctrl.irq_on_done ? done_evt : load_evt;
      if (busy && stb) begin
        if (lvl) begin
          lvl <= 1'b0;
          if (bit_cnt != '0) tx_sh <= tx_advance(tx_sh, ctrl.msb_first);
        end else begin
          lvl     <= 1'b1;
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (frame_end) begin
            busy <= 1'b0;
            rx_q <= rx_next;
          end
        end
      end
      if (load_evt) begin
        tx_sh   <= buf_q;
        busy    <= 1'b1;
        lvl     <= 1'b1;
        bit_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      rx_full  <= 1'b0;
    end else begin
      if (wr_buf) begin
        buf_q    <= wr_data;
        buf_full <= 1'b1;
      end else if (load_evt) begin
        buf_full <= 1'b0;
      end
      if (frame_end)   rx_full <= 1'b1;
      else if (rx_clr) rx_full <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_sync_serial.sv
module ssp_sync_serial
  import ssp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int MID_DIV  = 8,
  parameter int SLOW_DIV = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cts_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sclk_out,
  output logic              irq_tx
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl;
  logic [DIV_W-1:0]  div_n;
  logic              src_tick, baud_stb;
  logic              busy, lvl, load_evt, frame_end, done_evt;
  logic              buf_full, rx_full;
  logic [DATA_W-1:0] buf_q, rx_q;
  logic              wr_buf, rx_clr;

  assign wr_buf   = reg_wr && (reg_addr == A_TXBUF);
  assign rx_clr   = reg_rd && (reg_addr == A_RXBUF);
  assign sclk_out = lvl ^ ctrl.clk_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      div_n <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl  <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
      if (reg_addr == A_DIV)  div_n <= reg_wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = DATA_W'(ctrl);
      A_DIV:    reg_rdata = DATA_W'(div_n);
      A_TXBUF:  reg_rdata = buf_q;
      A_RXBUF:  reg_rdata = rx_q;
      A_STATUS: reg_rdata = DATA_W'({rx_full, !busy, !buf_full});
      default:  reg_rdata = '0;
    endcase
  end

  ssp_prescale #(.MID_DIV(MID_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_sel(ctrl.src_sel), .src_tick(src_tick)
  );

  ssp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy), .clr(load_evt),
    .tick(src_tick), .n(div_n), .stb(baud_stb)
  );

  ssp_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .wr_buf(wr_buf), .wr_data(reg_wdata),
    .rx_clr(rx_clr), .cts_n(cts_n), .sdi(sdi), .stb(baud_stb),
    .busy(busy), .lvl(lvl), .load_evt(load_evt), .frame_end(frame_end),
    .done_evt(done_evt), .buf_full(buf_full), .buf_q(buf_q), .rx_q(rx_q),
    .rx_full(rx_full), .sdo(sdo), .irq_tx(irq_tx)
  );
endmodule

// File: rtl/ssp_sync_serial_chk.sv
module ssp_sync_serial_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cts_n,
  input logic       sdo,
  input logic       sclk_out,
  input logic       irq_tx,
  input logic [1:0] src_sel,
  input logic       clk_pol,
  input logic       cts_en,
  input logic       src_tick,
  input logic       busy,
  input logic       load_evt,
  input logic       frame_end,
  input logic       rx_full
);
  AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (src_sel == 2'b11) |-> !src_tick); // R2
  AST_INHIBIT_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (src_sel == 2'b11 && !busy) |=> !busy); // R2
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sclk_out == !clk_pol)); // R3
  AST_IDLE_SDO: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sdo); // R4
  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && load_evt) |=> busy); // R7
  AST_RX_FLAG: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> rx_full); // R9
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (load_evt && cts_en) |-> !cts_n); // R10
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq_tx |=> !irq_tx); // R11
endmodule

bind ssp_sync_serial ssp_sync_serial_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .sdo(sdo), .sclk_out(sclk_out),
  .irq_tx(irq_tx), .src_sel(ctrl.src_sel), .clk_pol(ctrl.clk_pol),
  .cts_en(ctrl.cts_en), .src_tick(src_tick), .busy(busy), .load_evt(load_evt),
  .frame_end(frame_end), .rx_full(rx_full)
);

// File: tb/ssp_sync_serial_test.sv
module ssp_sync_serial_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = 3'd4;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       cts_n = 1'b0, sdi = 1'b1;
  logic       sdo, sclk_out, irq_tx;

  int total = 0, bad = 0;
  int irq_count = 0;
  logic loop_mode = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int         m_pre, m_dcnt, m_bits, m_oidx;
  logic       m_busy, m_lvl, m_bfull, m_rxf, m_irq;
  logic [7:0] m_tx, m_rx, m_buf, m_rxq, m_div;
  logic [6:0] m_ctrl;

  // leading-edge capture of sdo
  logic [7:0] cap_bits;
  int         cap_n = 0;
  logic       prev_sclk = 1'b1;

  ssp_sync_serial uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cts_n(cts_n), .sdi(sdi),
    .sdo(sdo), .sclk_out(sclk_out), .irq_tx(irq_tx)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // serial input: loopback of sdo or a pseudo-random stream, changed after each edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sdi  = loop_mode ? sdo : lfsr[0];
  end

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    logic tick, stb, can, last, load, done;
    int   pos;
    if (!rst_n) begin
      m_pre = 0; m_dcnt = 0; m_bits = 0; m_oidx = 0;
      m_busy = 0; m_lvl = 1; m_bfull = 0; m_rxf = 0; m_irq = 0;
      m_tx = 0; m_rx = 0; m_buf = 0; m_rxq = 0; m_div = 0; m_ctrl = 0;
    end else begin
      tick = (m_ctrl[1:0] == 2'd0) || (m_ctrl[1:0] == 2'd1 && m_pre % 8 == 7) ||
             (m_ctrl[1:0] == 2'd2 && m_pre % 32 == 31);
      stb  = m_busy && tick && (m_dcnt == int'(m_div));
      can  = m_bfull && (!m_ctrl[5] || !cts_n) && (m_ctrl[1:0] != 2'd3);
      last = stb && !m_lvl && (m_bits == 7);
      load = can && (!m_busy || last);
      done = last && !can;
      m_irq = m_ctrl[6] ? done : load;
      if (load) m_dcnt = 0;
      else if (m_busy && tick) m_dcnt = stb ? 0 : m_dcnt + 1;
      if (stb) begin
        if (m_lvl) begin
          m_lvl = 0; m_oidx = m_bits;
        end else begin
          m_lvl = 1;
          pos = m_ctrl[3] ? 7 - m_bits : m_bits;
          m_rx[pos] = sdi ^ m_ctrl[4];
          m_bits++;
          if (last) begin m_busy = 0; m_rxq = m_rx; end
        end
      end
      if (load) begin m_tx = m_buf; m_busy = 1; m_lvl = 1; m_bits = 0; m_oidx = 0; end
      if (reg_wr && reg_addr == 3'd2) begin m_buf = reg_wdata; m_bfull = 1; end
      else if (load) m_bfull = 0;
      if (last) m_rxf = 1;
      else if (reg_rd && reg_addr == 3'd3) m_rxf = 0;
      if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata[6:0];
      if (reg_wr && reg_addr == 3'd1) m_div = reg_wdata;
      m_pre = (m_pre + 1) % 32;
    end
  end

  function automatic logic [7:0] model_rdata();
    case (reg_addr)
      3'd0: return {1'b0, m_ctrl};
      3'd1: return m_div;
      3'd2: return m_buf;
      3'd3: return m_rxq;
      3'd4: return {5'd0, m_rxf, !m_busy, !m_bfull};
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison and observation, away from the active edge
  always @(negedge clk) begin
    logic exp_sdo;
    if (rst_n) begin
      exp_sdo = m_busy ? (m_tx[m_ctrl[3] ? 7 - m_oidx : m_oidx] ^ m_ctrl[4]) : 1'b1;
      chk("R3 sclk_out", sclk_out, m_lvl ^ m_ctrl[2]);
      chk("R4 sdo", sdo, exp_sdo);
      chk("R11 irq_tx", irq_tx, m_irq);
      chk("R7 reg_rdata", reg_rdata, model_rdata());
      if (irq_tx) irq_count++;
      if (sclk_out != prev_sclk && sclk_out == m_ctrl[2] && cap_n < 8) begin
        cap_bits[cap_n] = sdo;
        cap_n++;
      end
    end
    prev_sclk = sclk_out;
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic rd_rx(output logic [7:0] v);
    @(posedge clk); #2;
    reg_addr = 3'd3; reg_rd = 1'b1;
    @(negedge clk); v = reg_rdata;
    @(posedge clk); #2;
    reg_rd = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic status(output logic [7:0] v);
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (reg_rdata[1:0] == 2'b11) break;
    end
  endtask

  // cycles between the first two changes of sclk_out after the call
  task automatic half_period(output int cyc);
    logic p;
    @(negedge clk); p = sclk_out;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (sclk_out != p) break; end
    p = sclk_out; cyc = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); cyc++; if (sclk_out != p) break; end
  endtask

  task automatic run_all();
    logic [7:0] v;
    int cyc;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    status(v);
    chk("R1 status", v, 8'h03);
    chk("R1 sclk", sclk_out, 1);
    chk("R1 sdo", sdo, 1);
    chk("R1 irq", irq_tx, 0);

    // inhibited source holds the byte
    wr_reg(3'd0, 8'h03);
    wr_reg(3'd2, 8'h5A);
    repeat (40) @(posedge clk);
    status(v);
    chk("R2 inhibited status", v, 8'h02);
    wr_reg(3'd0, 8'h00);
    wait_idle();
    status(v);
    chk("R9 rx flag set", v, 8'h07);
    rd_rx(v);
    chk("R9 loopback byte", v, 8'h5A);
    status(v);
    chk("R9 rx flag cleared", v, 8'h03);

    // half periods
    wr_reg(3'd1, 8'd2);
    wr_reg(3'd2, 8'h33);
    half_period(cyc);
    chk("R3 half period f1 N=2", cyc, 3);
    wait_idle();
    wr_reg(3'd0, 8'h01);
    wr_reg(3'd1, 8'd0);
    wr_reg(3'd2, 8'hC3);
    half_period(cyc);
    chk("R2 half period f8 N=0", cyc, 8);
    wait_idle();
    wr_reg(3'd0, 8'h02);
    wr_reg(3'd1, 8'd1);
    wr_reg(3'd2, 8'h0F);
    half_period(cyc);
    chk("R2 half period f32 N=1", cyc, 64);
    wait_idle();

    // bit order and inversion, observed at leading edges
    wr_reg(3'd1, 8'd0);
    wr_reg(3'd0, 8'h08);
    cap_n = 0;
    wr_reg(3'd2, 8'hB4);
    wait_idle();
    for (int k = 0; k < 8; k++) chk("R5 msb-first bit", cap_bits[k], (8'hB4 >> (7 - k)) & 1);
    wr_reg(3'd0, 8'h00);
    cap_n = 0;
    wr_reg(3'd2, 8'hB4);
    wait_idle();
    for (int k = 0; k < 8; k++) chk("R5 lsb-first bit", cap_bits[k], (8'hB4 >> k) & 1);
    wr_reg(3'd0, 8'h18);
    cap_n = 0;
    wr_reg(3'd2, 8'h96);
    wait_idle();
    for (int k = 0; k < 8; k++) chk("R6 inverted bit", cap_bits[k], ((8'h96 >> (7 - k)) & 1) ^ 1);
    rd_rx(v);
    chk("R6 inverted loopback", v, 8'h96);

    // random input stream, model-checked capture
    loop_mode = 1'b0;
    wr_reg(3'd0, 8'h10);
    wr_reg(3'd2, 8'h21);
    wait_idle();
    rd_rx(v);
    chk("R6 rx random stream", v, m_rxq);
    loop_mode = 1'b1;

    // polarity 1 rest level
    wr_reg(3'd0, 8'h04);
    @(negedge clk);
    chk("R3 rest level pol1", sclk_out, 0);
    wr_reg(3'd0, 8'h00);

    // load from idle
    wr_reg(3'd2, 8'h11);
    status(v);
    chk("R7 queued", v, 8'h02);
    status(v);
    chk("R7 loaded", v, 8'h01);
    wait_idle();

    // back to back, interrupt on buffer empty
    irq_count = 0;
    wr_reg(3'd2, 8'hA1);
    wr_reg(3'd2, 8'h7E);
    cyc = 1;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (reg_rdata[1] == 1'b0) cyc++; end
    chk("R8 busy span", cyc, 32);
    chk("R11 irq count buffer mode", irq_count, 2);
    rd_rx(v);
    chk("R8 second byte received", v, 8'h7E);

    // back to back, interrupt on completion
    wr_reg(3'd0, 8'h40);
    irq_count = 0;
    wr_reg(3'd2, 8'h3C);
    wr_reg(3'd2, 8'hC5);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R11 irq count completion mode", irq_count, 1);

    // clear-to-send gating
    wr_reg(3'd0, 8'h20);
    cts_n = 1'b1;
    wr_reg(3'd2, 8'h55);
    repeat (30) @(posedge clk);
    status(v);
    chk("R10 held by cts", v & 8'h03, 8'h02);
    @(posedge clk); #2 cts_n = 1'b0;
    repeat (2) @(posedge clk);
    status(v);
    chk("R10 started", v & 8'h03, 8'h01);
    wait_idle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule